// File: doc/BRIEF.md
# Access Violation Interrupt Status Register

This block collects access-violation events from a memory protection unit and turns them into one level-sensitive interrupt line for an interrupt controller. Three single-cycle pulses report a security violation, a write-permission violation and a read-permission violation. Each pulse sets a sticky status bit. A fourth sticky bit records APB accesses to addresses that have no register behind them.

Software reaches the block over an APB slave port. It reads the status word and clears bits by writing ones. A separate 4-bit mask register gates each status bit off the interrupt line. Only the first AXI-side violation is kept. While any of the three AXI status bits is set, later violation pulses leave the status unchanged, so the recorded cause remains the earliest one until software clears it. The APB port never inserts wait states.

Top module: `vio_irq_stat`

## Requirements
- R1: After reset the status word reads 0, the mask register reads 0xF and the interrupt output is low.
- R2: The status register sits at offset 0x00 and the mask register at offset 0x04. Status bit 3 is security violation, bit 2 is write-permission violation, bit 1 is read-permission violation and bit 0 is APB access error. Bits 31:4 of both registers read as zero.
- R3: A write to the status offset clears each status bit whose write-data bit is 1. Data bits that are 0 leave the status unchanged.
- R4: A violation pulse sampled at a rising edge sets its status bit, and that bit is readable from the next cycle on.
- R5: The interrupt output is high exactly when some status bit is 1 and its mask bit is 0. The mask register is read/write through its 4 low bits.
- R6: While any of status bits 3:1 is set, further violation pulses do not change the status.
- R7: Violation pulses that arrive together while bits 3:1 are all clear are latched together.
- R8: An APB access to any other offset asserts PSLVERR in its access phase, returns zero read data and sets status bit 0 at the end of that transfer. Accesses to the two implemented offsets never assert PSLVERR.
- R9: If a write-1-to-clear and a new violation reach the same status bit in one cycle, the bit ends up set.
- R10: PREADY is high in every access phase, and read data is valid in that same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vio_sec_i | input | 1 | Security violation pulse |
| vio_wr_i | input | 1 | Write-permission violation pulse |
| vio_rd_i | input | 1 | Read-permission violation pulse |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, always high |
| pslverr_o | output | 1 | APB error response |
| irq_o | output | 1 | Interrupt request, level |

## Verification
PREADY, PSLVERR and read data are combinational in the access phase. The bench samples them one nanosecond after it raises PENABLE, which is before the rising edge that completes the transfer. Status and mask changes, and the interrupt level derived from them, take effect at the rising edge where the pulse or the access phase is sampled. The bench therefore checks the interrupt at the next falling edge and checks status through a later read. To cover the interrupt function, it sweeps every pattern of simultaneous violation pulses against all sixteen mask values, comparing the interrupt against a model the bench keeps of status and mask.

// File: rtl/vio_irq_pkg.sv
package vio_irq_pkg;
  localparam int unsigned NUM_SRC = 4;   // status bits
  localparam int unsigned AXI_SRC = 3;   // violation pulse sources (bits 3:1)
  localparam int unsigned STAT_OFS = 'h00;
  localparam int unsigned MASK_OFS = 'h04;

  typedef struct packed {
    logic rd_stat;
    logic rd_mask;
    logic wr_stat;
    logic wr_mask;
    logic bad;
  } acc_t;
endpackage

// File: rtl/vio_apb_dec.sv
module vio_apb_dec
  import vio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output acc_t               acc_o,
  output logic [DATA_W-1:0]  prdata_o,
  output logic               pready_o,
  output logic               pslverr_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic access;
  logic hit_stat;
  logic hit_mask;

  always_comb begin
    access   = psel_i & penable_i;
    hit_stat = (paddr_i == ADDR_W'(STAT_OFS));
    hit_mask = (paddr_i == ADDR_W'(MASK_OFS));

    acc_o.rd_stat = access & ~pwrite_i & hit_stat;
    acc_o.rd_mask = access & ~pwrite_i & hit_mask;
    acc_o.wr_stat = access &  pwrite_i & hit_stat;
    acc_o.wr_mask = access &  pwrite_i & hit_mask;
    acc_o.bad     = access & ~hit_stat & ~hit_mask;

    prdata_o = '0;
    if (acc_o.rd_stat) prdata_o = {{PAD_W{1'b0}}, stat_i};
    if (acc_o.rd_mask) prdata_o = {{PAD_W{1'b0}}, mask_i};

    pready_o  = 1'b1;
    pslverr_o = acc_o.bad;
  end

  // R8: error response only in an access phase
  a_r8_err_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr_o |-> (psel_i && penable_i));
  // R8: implemented offsets never answer with an error
  a_r8_no_err_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o.rd_stat || acc_o.wr_stat || acc_o.rd_mask || acc_o.wr_mask) |-> !pslverr_o);
endmodule

// File: rtl/vio_stat_core.sv
module vio_stat_core
  import vio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AXI_SRC-1:0] vio_i,
  input  acc_t               acc_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] stat_q, stat_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] set_v, clr_v;
  logic               axi_busy;
  logic               stat_en, mask_en;

  // next state
  always_comb begin
    axi_busy = |stat_q[NUM_SRC-1:1];
    set_v    = {(axi_busy ? {AXI_SRC{1'b0}} : vio_i), acc_i.bad};
    clr_v    = acc_i.wr_stat ? wdata_i : '0;
    stat_d   = (stat_q & ~clr_v) | set_v;
    stat_en  = (|set_v) | (|clr_v);
    mask_en  = acc_i.wr_mask;
    mask_d   = wdata_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_comb begin
    stat_o = stat_q;
    mask_o = mask_q;
    irq_o  = |(stat_q & ~mask_q);
  end

  // R3: cleared bits without a competing set read zero afterwards
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i.wr_stat && !(|vio_i) && !acc_i.bad) |=> ((stat_q & $past(wdata_i)) == '0));
  // R6: first AXI cause is held until software clears
  a_r6_first_held: assert property (@(posedge clk) disable iff (!rst_n)
    (axi_busy && !acc_i.wr_stat) |=> $stable(stat_q[NUM_SRC-1:1]));
  // R7 / R9: every pulse on an idle AXI field is latched, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!axi_busy && (|vio_i)) |=> ((stat_q[NUM_SRC-1:1] & $past(vio_i)) == $past(vio_i)));
  // R8: a bad access leaves the error bit set
  a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i.bad |=> stat_q[0]);
  // R5: nothing unmasked means no interrupt
  a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_q) || (stat_q == '0)) |-> !irq_o);
endmodule

// File: rtl/vio_irq_stat.sv
module vio_irq_stat
  import vio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vio_sec_i,
  input  logic              vio_wr_i,
  input  logic              vio_rd_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              irq_o
);
  acc_t               acc;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] mask;
  logic [AXI_SRC-1:0] vio;

  assign vio = {vio_sec_i, vio_wr_i, vio_rd_i};

  vio_apb_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .stat_i    (stat),
    .mask_i    (mask),
    .acc_o     (acc),
    .prdata_o  (prdata_o),
    .pready_o  (pready_o),
    .pslverr_o (pslverr_o)
  );

  vio_stat_core core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .vio_i   (vio),
    .acc_i   (acc),
    .wdata_i (pwdata_i[NUM_SRC-1:0]),
    .stat_o  (stat),
    .mask_o  (mask),
    .irq_o   (irq_o)
  );

  // R10: ready in every access phase
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_i && penable_i) |-> pready_o);
endmodule

// File: tb/vio_irq_stat_tb.sv
`timescale 1ns/1ps
module vio_irq_stat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vio_sec, vio_wr, vio_rd;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [3:0] exp_stat;
  logic [3:0] exp_mask;

  always #2.5 clk = ~clk;

  vio_irq_stat dut_i (
    .clk(clk), .rst_n(rst_n),
    .vio_sec_i(vio_sec), .vio_wr_i(vio_wr), .vio_rd_i(vio_rd),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one APB transfer; optional violation pulse during its access phase
  task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [2:0] v, output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1; {vio_sec, vio_wr, vio_rd} = v;
    #1;
    rd = prdata; err = pslverr;
    check("R10 pready", {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; {vio_sec, vio_wr, vio_rd} = 3'b000;
  endtask

  task automatic pulse(input logic [2:0] v);
    @(negedge clk);
    {vio_sec, vio_wr, vio_rd} = v;
    @(negedge clk);
    {vio_sec, vio_wr, vio_rd} = 3'b000;
    if (exp_stat[3:1] == 3'b000) exp_stat[3:1] = v;
  endtask

  task automatic rd_stat(input string req);
    logic [31:0] r; logic e;
    xfer(1'b0, 12'h000, 32'd0, 3'b000, r, e);
    check(req, r, {28'd0, exp_stat});
    check("R8 no err on status", {31'd0, e}, 32'd0);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    xfer(1'b1, a, d, 3'b000, r, e);
    if (a == 12'h000) exp_stat = exp_stat & ~d[3:0];
    if (a == 12'h004) exp_mask = d[3:0];
  endtask

  function automatic logic exp_irq();
    return |(exp_stat & ~exp_mask);
  endfunction

  initial begin
    logic [31:0] r;
    logic        e;
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    vio_sec = 0; vio_wr = 0; vio_rd = 0;
    exp_stat = 4'h0; exp_mask = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    rd_stat("R1 status after reset");
    xfer(1'b0, 12'h004, 32'd0, 3'b000, r, e);
    check("R1 mask after reset", r, 32'h0000000F);

    // R2/R4/R7/R5/R6 sweep over all pulse patterns and masks
    for (int v = 1; v < 8; v++) begin
      wr_reg(12'h000, 32'hFFFF_FFFF);
      pulse(3'(v));
      rd_stat("R4 R7 R2 latched pattern");
      for (int m = 0; m < 16; m++) begin
        wr_reg(12'h004, 32'hFFFF_FFF0 | 32'(m));
        check("R5 irq vs mask", {31'd0, irq}, {31'd0, exp_irq()});
        xfer(1'b0, 12'h004, 32'd0, 3'b000, r, e);
        check("R5 R2 mask readback", r, 32'(m));
      end
      pulse(3'b111);
      rd_stat("R6 later violations ignored");
      wr_reg(12'h000, 32'h0000_0000);
      rd_stat("R3 write zero no effect");
      wr_reg(12'h000, 32'h0000_0002);
      rd_stat("R3 clear single bit");
    end

    // R8 unimplemented offsets
    wr_reg(12'h000, 32'hF);
    wr_reg(12'h004, 32'hE);
    xfer(1'b0, 12'h008, 32'd0, 3'b000, r, e);
    check("R8 pslverr on bad read", {31'd0, e}, 32'd1);
    check("R8 zero data on bad read", r, 32'd0);
    exp_stat[0] = 1'b1;
    check("R8 R5 irq from error bit", {31'd0, irq}, 32'd1);
    rd_stat("R8 error bit set");
    wr_reg(12'h000, 32'h1);
    rd_stat("R3 error bit cleared");
    xfer(1'b1, 12'hFFC, 32'hFFFF_FFFF, 3'b000, r, e);
    check("R8 pslverr on bad write", {31'd0, e}, 32'd1);
    exp_stat[0] = 1'b1;
    rd_stat("R8 bad write flags, status untouched");
    xfer(1'b0, 12'h004, 32'd0, 3'b000, r, e);
    check("R8 bad write leaves mask", r, 32'hE);

    // R9 clear and new violation together
    wr_reg(12'h000, 32'hF);
    xfer(1'b1, 12'h000, 32'h0000_000E, 3'b001, r, e);
    exp_stat = 4'b0010;
    rd_stat("R9 set wins over clear");
    // clear of a held bit while a new pulse arrives: old cause gone, new not recorded
    xfer(1'b1, 12'h000, 32'h0000_0002, 3'b100, r, e);
    exp_stat = 4'b0000;
    rd_stat("R6 pulse ignored while busy");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule